// File: doc/BRIEF.md
# Pipeline Data Hazard Resolver

This block resolves read-after-write hazards in a five-stage integer pipeline. Registers are read in the second stage and written in the fifth, and every instruction takes all five stages, so write-after-read and write-after-write conflicts cannot arise. Only true dependences need handling. The block compares the two source register numbers of the instruction in execute against the destinations held in the execute/memory and memory/writeback pipeline registers. From that comparison it produces the select codes for the two ALU operand multiplexers. It also produces a select that lets a store in the memory stage take its data from the writeback stage.

The block also compares the sources of the instruction in decode against a load that sits in execute. If the loaded value is needed straight away, forwarding cannot deliver it in time. The block then holds the PC and the fetch/decode register for one cycle and inserts a bubble into execute. A store whose only dependence on the load is its data register does not stall, because the store-data path covers that case. Register 0 always reads as zero and never takes part in forwarding or stalling. The logic is purely combinational, so it adds no cycle of latency.

Top module: `hz_forward_unit`

## Requirements
- R1: Each ALU operand select is a 2-bit code: 2'b00 picks the register file, 2'b01 picks the memory/writeback result and 2'b10 picks the execute/memory result. Code 2'b11 never appears, and with no match the code is 2'b00.
- R2: When the execute/memory stage writes a nonzero register that equals an execute-stage source, that operand's select is 2'b10.
- R3: When only the memory/writeback stage writes a nonzero register that equals an execute-stage source, that operand's select is 2'b01.
- R4: When both stages write the register an execute-stage source reads, the execute/memory result wins and the select is 2'b10.
- R5: A stage whose write-enable input is low is never a forwarding source, whatever its destination number.
- R6: A destination of register 0 never causes forwarding or a stall.
- R7: The store-data select is 1 exactly when the memory stage holds a store and the writeback stage writes the nonzero register that the store's data comes from.
- R8: A load in execute with a nonzero destination stalls when the decode instruction uses that register as its first source, or as its second source when the decode instruction is not a store. The hold and bubble outputs are both 1 during the stall.
- R9: A store in decode whose only match with the load is its data (second) source causes no stall.
- R10: No stall occurs when the execute instruction is not a load, or when the matching decode source is flagged as unused.
- R11: The first operand select follows only the first execute source, and the second select follows only the second execute source.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| idex_rs_idx | input | 5 | First source register of the execute-stage instruction |
| idex_rt_idx | input | 5 | Second source register of the execute-stage instruction |
| exmem_wr_en | input | 1 | Execute/memory instruction writes a register |
| exmem_dst | input | 5 | Execute/memory destination register |
| memwb_wr_en | input | 1 | Memory/writeback instruction writes a register |
| memwb_dst | input | 5 | Memory/writeback destination register |
| exmem_store | input | 1 | Execute/memory instruction is a store |
| exmem_store_reg | input | 5 | Data source register of that store |
| ifid_rs_idx | input | 5 | First source register of the decode-stage instruction |
| ifid_rs_used | input | 1 | Decode instruction reads its first source |
| ifid_rt_idx | input | 5 | Second source register of the decode-stage instruction |
| ifid_rt_used | input | 1 | Decode instruction reads its second source |
| ifid_store | input | 1 | Decode instruction is a store |
| idex_load | input | 1 | Execute-stage instruction is a load |
| idex_load_dst | input | 5 | Destination register of that load |
| op_a_sel | output | 2 | First ALU operand select |
| op_b_sel | output | 2 | Second ALU operand select |
| st_data_sel | output | 1 | Store data taken from the writeback stage |
| hold_front | output | 1 | Hold PC and fetch/decode register |
| insert_bubble | output | 1 | Clear execute-stage control to a bubble |

## Verification
The bench builds the block with its default 5-bit register index, which gives 32 registers. With that width, both ends of the register range can be reached in directed cases: register 0, whose suppression is checked for forwarding, store data and stalls, and register 31, where every index bit is set. With that width the bench can also set the two pipeline destinations equal, to show the execute/memory priority, and can set one register on both decode sources, to show the store-data exemption from the stall.

// File: rtl/hz_pkg.sv
package hz_pkg;

    localparam int REG_IDX_W = 5;
    localparam int NUM_SRC   = 2;

    typedef logic [REG_IDX_W-1:0] reg_idx_t;

    typedef enum logic [1:0] {
        OPSEL_RF  = 2'b00,
        OPSEL_WB  = 2'b01,
        OPSEL_MEM = 2'b10
    } opsel_e;

    typedef struct packed {
        logic     wr_en;
        reg_idx_t dst;
    } wr_port_t;

    typedef struct packed {
        reg_idx_t idx;
        logic     used;
    } rd_port_t;

    // A writing stage matches a reader unless it targets the zero register.
    function automatic logic wr_hits(wr_port_t w, reg_idx_t src);
        return w.wr_en && (w.dst != '0) && (w.dst == src);
    endfunction

endpackage

// File: rtl/hz_operand_fwd.sv
module hz_operand_fwd
    import hz_pkg::*;
(
    input  reg_idx_t src,
    input  wr_port_t mem_wr,
    input  wr_port_t wb_wr,
    output opsel_e   sel
);
    // The younger result in execute/memory is checked first.
    always_comb begin
        if (wr_hits(mem_wr, src))
            sel = OPSEL_MEM;
        else if (wr_hits(wb_wr, src))
            sel = OPSEL_WB;
        else
            sel = OPSEL_RF;
    end
endmodule

// File: rtl/hz_store_fwd.sv
module hz_store_fwd
    import hz_pkg::*;
(
    input  logic     st_in_mem,
    input  reg_idx_t st_data_reg,
    input  wr_port_t wb_wr,
    output logic     fwd
);
    always_comb fwd = st_in_mem && wr_hits(wb_wr, st_data_reg);
endmodule

// File: rtl/hz_load_use.sv
module hz_load_use
    import hz_pkg::*;
(
    input  logic     ld_in_ex,
    input  reg_idx_t ld_dst,
    input  rd_port_t rs_port,
    input  rd_port_t rt_port,
    input  logic     is_store,
    output logic     stall
);
    wr_port_t ld_wr;
    logic     rs_hit;
    logic     rt_hit;

    always_comb begin
        ld_wr  = '{wr_en: ld_in_ex, dst: ld_dst};
        rs_hit = rs_port.used && wr_hits(ld_wr, rs_port.idx);
        // Store data can be picked up later from writeback, no stall needed.
        rt_hit = rt_port.used && !is_store && wr_hits(ld_wr, rt_port.idx);
        stall  = rs_hit || rt_hit;
    end
endmodule

// File: rtl/hz_forward_unit.sv
module hz_forward_unit
    import hz_pkg::*;
(
    input  logic [REG_IDX_W-1:0] idex_rs_idx,
    input  logic [REG_IDX_W-1:0] idex_rt_idx,
    input  logic                 exmem_wr_en,
    input  logic [REG_IDX_W-1:0] exmem_dst,
    input  logic                 memwb_wr_en,
    input  logic [REG_IDX_W-1:0] memwb_dst,
    input  logic                 exmem_store,
    input  logic [REG_IDX_W-1:0] exmem_store_reg,
    input  logic [REG_IDX_W-1:0] ifid_rs_idx,
    input  logic                 ifid_rs_used,
    input  logic [REG_IDX_W-1:0] ifid_rt_idx,
    input  logic                 ifid_rt_used,
    input  logic                 ifid_store,
    input  logic                 idex_load,
    input  logic [REG_IDX_W-1:0] idex_load_dst,
    output logic [1:0]           op_a_sel,
    output logic [1:0]           op_b_sel,
    output logic                 st_data_sel,
    output logic                 hold_front,
    output logic                 insert_bubble
);
    wr_port_t mem_wr;
    wr_port_t wb_wr;
    reg_idx_t ex_src [NUM_SRC];
    opsel_e   ex_sel [NUM_SRC];
    logic     stall;

    assign mem_wr    = '{wr_en: exmem_wr_en, dst: exmem_dst};
    assign wb_wr     = '{wr_en: memwb_wr_en, dst: memwb_dst};
    assign ex_src[0] = idex_rs_idx;
    assign ex_src[1] = idex_rt_idx;

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_opnd
        hz_operand_fwd u_fwd (
            .src    (ex_src[g]),
            .mem_wr (mem_wr),
            .wb_wr  (wb_wr),
            .sel    (ex_sel[g])
        );
    end

    assign op_a_sel = ex_sel[0];
    assign op_b_sel = ex_sel[1];

    hz_store_fwd u_st (
        .st_in_mem   (exmem_store),
        .st_data_reg (exmem_store_reg),
        .wb_wr       (wb_wr),
        .fwd         (st_data_sel)
    );

    hz_load_use u_lu (
        .ld_in_ex (idex_load),
        .ld_dst   (idex_load_dst),
        .rs_port  ('{idx: ifid_rs_idx, used: ifid_rs_used}),
        .rt_port  ('{idx: ifid_rt_idx, used: ifid_rt_used}),
        .is_store (ifid_store),
        .stall    (stall)
    );

    assign hold_front    = stall;
    assign insert_bubble = stall;
endmodule

// File: rtl/hz_forward_unit_chk.sv
module hz_forward_unit_chk
    import hz_pkg::*;
(
    input logic [REG_IDX_W-1:0] idex_rs_idx,
    input logic [REG_IDX_W-1:0] idex_rt_idx,
    input logic                 exmem_wr_en,
    input logic [REG_IDX_W-1:0] exmem_dst,
    input logic                 memwb_wr_en,
    input logic [REG_IDX_W-1:0] memwb_dst,
    input logic                 exmem_store,
    input logic [REG_IDX_W-1:0] exmem_store_reg,
    input logic                 idex_load,
    input logic [REG_IDX_W-1:0] idex_load_dst,
    input logic [1:0]           op_a_sel,
    input logic [1:0]           op_b_sel,
    input logic                 st_data_sel,
    input logic                 hold_front,
    input logic                 insert_bubble
);
    always_comb begin
        if (!$isunknown({idex_rs_idx, idex_rt_idx, exmem_wr_en, exmem_dst, memwb_wr_en,
                         memwb_dst, exmem_store, exmem_store_reg, idex_load, idex_load_dst,
                         op_a_sel, op_b_sel, st_data_sel, hold_front, insert_bubble})) begin
            AST_SEL_LEGAL: assert (op_a_sel != 2'b11 && op_b_sel != 2'b11)
                else $error("illegal operand select"); // R1
            AST_A_MEM_SRC: assert (op_a_sel != 2'b10 ||
                                   (exmem_wr_en && exmem_dst == idex_rs_idx))
                else $error("operand A from a non-matching memory stage"); // R2
            AST_B_WB_SRC: assert (op_b_sel != 2'b01 ||
                                  (memwb_wr_en && memwb_dst == idex_rt_idx))
                else $error("operand B from a non-matching writeback stage"); // R3
            AST_MEM_PRIORITY: assert (!(exmem_wr_en && exmem_dst != '0 &&
                                        exmem_dst == idex_rs_idx) || op_a_sel == 2'b10)
                else $error("memory stage lost priority"); // R4
            AST_ZERO_SRC: assert (idex_rs_idx != '0 || op_a_sel == 2'b00)
                else $error("register 0 forwarded"); // R6
            AST_STORE_FWD_SRC: assert (!st_data_sel || (exmem_store && memwb_wr_en &&
                                       memwb_dst == exmem_store_reg && memwb_dst != '0))
                else $error("store data forwarded without a source"); // R7
            AST_STALL_PAIR: assert (hold_front == insert_bubble)
                else $error("hold and bubble disagree"); // R8
            AST_STALL_NEEDS_LOAD: assert (!hold_front || (idex_load && idex_load_dst != '0))
                else $error("stall without a load"); // R10
        end
    end
endmodule

bind hz_forward_unit hz_forward_unit_chk chk_i (
    .idex_rs_idx     (idex_rs_idx),
    .idex_rt_idx     (idex_rt_idx),
    .exmem_wr_en     (exmem_wr_en),
    .exmem_dst       (exmem_dst),
    .memwb_wr_en     (memwb_wr_en),
    .memwb_dst       (memwb_dst),
    .exmem_store     (exmem_store),
    .exmem_store_reg (exmem_store_reg),
    .idex_load       (idex_load),
    .idex_load_dst   (idex_load_dst),
    .op_a_sel        (op_a_sel),
    .op_b_sel        (op_b_sel),
    .st_data_sel     (st_data_sel),
    .hold_front      (hold_front),
    .insert_bubble   (insert_bubble)
);

// File: tb/hz_forward_unit_tb_top.sv
`timescale 1ns/1ps
module hz_forward_unit_tb_top;
    logic       clk = 1'b0;
    logic [4:0] idex_rs_idx, idex_rt_idx, exmem_dst, memwb_dst, exmem_store_reg;
    logic [4:0] ifid_rs_idx, ifid_rt_idx, idex_load_dst;
    logic       exmem_wr_en, memwb_wr_en, exmem_store, ifid_rs_used, ifid_rt_used;
    logic       ifid_store, idex_load;
    logic [1:0] op_a_sel, op_b_sel;
    logic       st_data_sel, hold_front, insert_bubble;
    int         n_run = 0;
    int         n_fail = 0;
    bit         done = 1'b0;

    always #2.5 clk = ~clk;

    hz_forward_unit dut_i (.*);

    task automatic chk(string req, logic [1:0] act, logic [1:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %b expected %b", req, act, exp);
        end
    endtask

    task automatic idle();
        @(negedge clk);
        idex_rs_idx = 0; idex_rt_idx = 0; exmem_wr_en = 0; exmem_dst = 0;
        memwb_wr_en = 0; memwb_dst = 0; exmem_store = 0; exmem_store_reg = 0;
        ifid_rs_idx = 0; ifid_rs_used = 0; ifid_rt_idx = 0; ifid_rt_used = 0;
        ifid_store = 0; idex_load = 0; idex_load_dst = 0;
    endtask

    task automatic t_idle();
        idle(); #1;
        chk("R1 idle A", op_a_sel, 2'b00);
        chk("R1 idle B", op_b_sel, 2'b00);
        chk("R1 idle store", {1'b0, st_data_sel}, 2'b00);
        chk("R1 idle hold", {insert_bubble, hold_front}, 2'b00);
    endtask

    task automatic t_mem_fwd();
        idle(); idex_rs_idx = 3; idex_rt_idx = 4; exmem_wr_en = 1; exmem_dst = 3; #1;
        chk("R2 mem fwd A", op_a_sel, 2'b10);
        chk("R11 B unaffected", op_b_sel, 2'b00);
    endtask

    task automatic t_wb_fwd();
        idle(); idex_rs_idx = 6; idex_rt_idx = 7; memwb_wr_en = 1; memwb_dst = 7; #1;
        chk("R3 wb fwd B", op_b_sel, 2'b01);
        chk("R11 A unaffected", op_a_sel, 2'b00);
    endtask

    task automatic t_priority();
        idle(); idex_rs_idx = 5; idex_rt_idx = 5;
        exmem_wr_en = 1; exmem_dst = 5; memwb_wr_en = 1; memwb_dst = 5; #1;
        chk("R4 priority A", op_a_sel, 2'b10);
        chk("R4 priority B", op_b_sel, 2'b10);
        idle(); idex_rs_idx = 31; idex_rt_idx = 30;
        exmem_wr_en = 1; exmem_dst = 30; memwb_wr_en = 1; memwb_dst = 31; #1;
        chk("R11 r31 A from wb", op_a_sel, 2'b01);
        chk("R11 r30 B from mem", op_b_sel, 2'b10);
    endtask

    task automatic t_wr_en();
        idle(); idex_rs_idx = 5; exmem_dst = 5; memwb_wr_en = 1; memwb_dst = 5; #1;
        chk("R5 mem disabled falls to wb", op_a_sel, 2'b01);
        memwb_wr_en = 0; #1;
        chk("R5 both disabled", op_a_sel, 2'b00);
        exmem_store = 1; exmem_store_reg = 5; #1;
        chk("R5 store no wb write", {1'b0, st_data_sel}, 2'b00);
    endtask

    task automatic t_zero();
        idle(); exmem_wr_en = 1; memwb_wr_en = 1; #1;
        chk("R6 r0 A", op_a_sel, 2'b00);
        chk("R6 r0 B", op_b_sel, 2'b00);
        exmem_store = 1; #1;
        chk("R6 r0 store", {1'b0, st_data_sel}, 2'b00);
        idex_load = 1; ifid_rs_used = 1; ifid_rt_used = 1; #1;
        chk("R6 r0 no stall", {insert_bubble, hold_front}, 2'b00);
    endtask

    task automatic t_store_fwd();
        idle(); exmem_store = 1; exmem_store_reg = 4; memwb_wr_en = 1; memwb_dst = 4; #1;
        chk("R7 store fwd", {1'b0, st_data_sel}, 2'b01);
        memwb_dst = 9; #1;
        chk("R7 store other reg", {1'b0, st_data_sel}, 2'b00);
        memwb_dst = 4; exmem_store = 0; #1;
        chk("R7 not a store", {1'b0, st_data_sel}, 2'b00);
    endtask

    task automatic t_load_use();
        idle(); idex_load = 1; idex_load_dst = 1; ifid_rs_idx = 1; ifid_rs_used = 1; #1;
        chk("R8 stall on rs", {insert_bubble, hold_front}, 2'b11);
        ifid_rs_idx = 2; ifid_rt_idx = 1; ifid_rt_used = 1; #1;
        chk("R8 stall on rt", {insert_bubble, hold_front}, 2'b11);
    endtask

    task automatic t_store_exempt();
        idle(); idex_load = 1; idex_load_dst = 4; ifid_store = 1;
        ifid_rs_idx = 1; ifid_rs_used = 1; ifid_rt_idx = 4; ifid_rt_used = 1; #1;
        chk("R9 store data no stall", {insert_bubble, hold_front}, 2'b00);
        ifid_rs_idx = 4; #1;
        chk("R9 store base stalls", {insert_bubble, hold_front}, 2'b11);
    endtask

    task automatic t_no_stall();
        idle(); idex_load_dst = 8; ifid_rs_idx = 8; ifid_rs_used = 1; #1;
        chk("R10 not a load", {insert_bubble, hold_front}, 2'b00);
        idex_load = 1; ifid_rs_used = 0; ifid_rt_idx = 8; #1;
        chk("R10 unused sources", {insert_bubble, hold_front}, 2'b00);
    endtask

    initial begin
        t_idle();
        t_mem_fwd();
        t_wb_fwd();
        t_priority();
        t_wr_en();
        t_zero();
        t_store_fwd();
        t_load_use();
        t_store_exempt();
        t_no_stall();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule